// File: doc/BRIEF.md
# Fault-Hardened Sequencing Controller

This block sequences one sensitive operation and is built to survive fault injection on its state register. A `start` request in the idle state opens a wait phase whose length comes from the `delayCycles` input. After the wait, the operation-enable output is held for a fixed number of cycles. A single-cycle done pulse follows, and then the controller returns to idle. `abort` cancels a pending or running operation.

The state register holds 8-bit codes, and every legal code has exactly four bits set. Any two legal codes differ in at least four positions, so a single or triple bit upset cannot turn one legal state into another. Each cycle the controller tests the register for the right weight and for membership in the legal set. If either test fails, it clears its outputs, raises `alert` in the same cycle and moves into a sticky error state. Only reset leaves that state.

The counter that ends the wait and run phases is loaded with an offset from a terminal value made of alternating ones and zeros. A phase therefore never ends because a register was forced to all-zeros or all-ones.

Top module: `fault_guard_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `stateCode` is 8'h0F (idle) and `opEnable`, `done` and `alert` are low.
- R2: The legal state codes are: idle 8'h0F, waiting 8'h33, running 8'hC3, finishing 8'h55 and error 8'hAA. `stateCode` always shows the current code.
- R3: A `start` that is high at a rising edge in idle, with `abort` low at that edge, moves the controller to waiting. Waiting lasts `delayCycles`+1 cycles, where `delayCycles` is sampled at that start edge, and then the controller moves to running. This holds at both extremes: 0 gives one cycle and 255 gives 256 cycles.
- R4: Running lasts RunCycles cycles (3 by default). `opEnable` is high in exactly those cycles and in no other state.
- R5: After running, `done` is high for exactly one cycle with `stateCode` 8'h55, and the controller is idle in the next cycle.
- R6: `abort` high at an edge while waiting or running returns the controller to idle at that edge, and no `done` pulse follows.
- R7: `start` is ignored outside idle. `abort` in idle is ignored and also blocks a `start` that arrives at the same edge.
- R8: If the state register holds any code outside the legal set, whether of the wrong weight or of weight four but unlisted, `alert` rises in that same cycle and `opEnable` and `done` are low. The code becomes 8'hAA at the next edge.
- R9: The error state is sticky. It ignores `start` and `abort`, holds `alert` high in every cycle, keeps `opEnable` and `done` low, and is left only through reset, which returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin the operation sequence |
| abort | input | 1 | Cancel a pending or running operation |
| delayCycles | input | 8 | Wait length, sampled when `start` is accepted |
| opEnable | output | 1 | High while the protected operation may run |
| done | output | 1 | One-cycle pulse when the operation finishes |
| alert | output | 1 | High while the state register is illegal or in error |
| stateCode | output | 8 | Current state register code |

## Verification
The sequencing is driven with wait lengths of 0, 1, 7 and 255. These show that the terminal-count offset is right at both wrap boundaries and that the run phase does not depend on the wait value. Aborts in the middle of waiting and during running, plus start requests held high through a busy sequence, check that the cancel paths skip the done pulse and that a busy controller does not restart. The state register is then overwritten with a wrong-weight code, an unlisted weight-four code and a one-bit flip of the running code. These show that the weight check and the membership check each trap on their own and that the outputs clear before the next edge.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  localparam int StateWidth = 8;

  // All legal codes have weight four; pairwise distance is at least four.
  localparam logic [StateWidth-1:0] StIdle  = 8'h0F;
  localparam logic [StateWidth-1:0] StWait  = 8'h33;
  localparam logic [StateWidth-1:0] StRun   = 8'hC3;
  localparam logic [StateWidth-1:0] StDone  = 8'h55;
  localparam logic [StateWidth-1:0] StError = 8'hAA;

  localparam int LegalWeight = 4;

  // Strobes from the control into the counter datapath.
  typedef struct packed {
    logic loadWait;
    logic loadRun;
    logic step;
  } ctrlStrobes_t;

endpackage

// File: rtl/fault_guard_counter.sv
module fault_guard_counter #(
  parameter int CntWidth  = 8,
  parameter int RunCycles = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fault_guard_pkg::ctrlStrobes_t strobes,
  input  logic [CntWidth-1:0]           delayCycles,
  output logic                          atTerm
);

  // Terminal value alternates ones and zeros: never all-0 nor all-1.
  function automatic logic [CntWidth-1:0] termPattern();
    logic [CntWidth-1:0] t;
    for (int i = 0; i < CntWidth; i++) t[i] = i[0];
    return t;
  endfunction

  localparam logic [CntWidth-1:0] TermValue = termPattern();
  localparam logic [CntWidth-1:0] RunSpan   = CntWidth'(RunCycles - 1);

  logic [CntWidth-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.loadWait) begin
      cntQ <= TermValue - delayCycles;
    end else if (strobes.loadRun) begin
      cntQ <= TermValue - RunSpan;
    end else if (strobes.step) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign atTerm = (cntQ == TermValue);

endmodule

// File: rtl/fault_guard_ctrl.sv
module fault_guard_ctrl
  import fault_guard_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  abort,
  input  logic                  atTerm,
  output ctrlStrobes_t          strobes,
  output logic                  opEnable,
  output logic                  done,
  output logic                  alert,
  output logic [StateWidth-1:0] stateCode
);

  logic [StateWidth-1:0] stateQ, stateD;
  logic weightOk, memberOk, legal;

  always_comb begin
    weightOk = ($countones(stateQ) == LegalWeight);
    memberOk = (stateQ == StIdle) || (stateQ == StWait) || (stateQ == StRun) ||
               (stateQ == StDone) || (stateQ == StError);
    legal    = weightOk && memberOk;
  end

  always_comb begin
    stateD  = StError;
    strobes = '0;
    if (legal) begin
      unique case (stateQ)
        StIdle: begin
          stateD = StIdle;
          if (start && !abort) begin
            stateD           = StWait;
            strobes.loadWait = 1'b1;
          end
        end
        StWait: begin
          if (abort) begin
            stateD = StIdle;
          end else if (atTerm) begin
            stateD          = StRun;
            strobes.loadRun = 1'b1;
          end else begin
            stateD       = StWait;
            strobes.step = 1'b1;
          end
        end
        StRun: begin
          if (abort) begin
            stateD = StIdle;
          end else if (atTerm) begin
            stateD = StDone;
          end else begin
            stateD       = StRun;
            strobes.step = 1'b1;
          end
        end
        StDone:  stateD = StIdle;
        default: stateD = StError;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= StIdle;
    else       stateQ <= stateD;
  end

  // Outputs decode exact codes only, so an illegal code clears them.
  assign opEnable  = legal && (stateQ == StRun);
  assign done      = legal && (stateQ == StDone);
  assign alert     = !legal || (stateQ == StError);
  assign stateCode = stateQ;

endmodule

// File: rtl/fault_guard_seq.sv
module fault_guard_seq #(
  parameter int RunCycles = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       abort,
  input  logic [7:0] delayCycles,
  output logic       opEnable,
  output logic       done,
  output logic       alert,
  output logic [7:0] stateCode
);

  fault_guard_pkg::ctrlStrobes_t strobes;
  logic atTerm;

  fault_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .abort     (abort),
    .atTerm    (atTerm),
    .strobes   (strobes),
    .opEnable  (opEnable),
    .done      (done),
    .alert     (alert),
    .stateCode (stateCode)
  );

  fault_guard_counter #(
    .CntWidth  (8),
    .RunCycles (RunCycles)
  ) u_counter (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .delayCycles (delayCycles),
    .atTerm      (atTerm)
  );

endmodule

// File: rtl/fault_guard_seq_checker.sv
module fault_guard_seq_checker
  import fault_guard_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       abort,
  input logic       opEnable,
  input logic       done,
  input logic       alert,
  input logic [7:0] stateCode
);

  p_state_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(stateCode) != LegalWeight) |-> alert);

  p_start_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == StIdle && start && !abort) |=> (stateCode == StWait));

  p_run_from_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opEnable) |-> ($past(stateCode) == StWait));

  p_outputs_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opEnable, done, alert}));

  p_done_then_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (stateCode == StIdle && !done));

  p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((stateCode == StWait || stateCode == StRun) && abort) |=> (stateCode == StIdle));

  p_idle_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == StIdle && abort) |=> (stateCode == StIdle));

  p_error_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == StError) |=> (stateCode == StError && alert));

  always_comb begin
    if (rstN && (stateCode == StError)) begin
      a_error_quiet_r9: assert (!opEnable && !done);
    end
  end

endmodule

bind fault_guard_seq fault_guard_seq_checker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .abort     (abort),
  .opEnable  (opEnable),
  .done      (done),
  .alert     (alert),
  .stateCode (stateCode)
);

// File: tb/fault_guard_seq_bench.sv
module fault_guard_seq_bench;

  localparam logic [7:0] CodeIdle  = 8'h0F;
  localparam logic [7:0] CodeWait  = 8'h33;
  localparam logic [7:0] CodeRun   = 8'hC3;
  localparam logic [7:0] CodeDone  = 8'h55;
  localparam logic [7:0] CodeError = 8'hAA;
  localparam int RunLen = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic [7:0] delayCycles = '0;
  logic       opEnable, done, alert;
  logic [7:0] stateCode;
  logic [7:0] faultCode = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fault_guard_seq #(.RunCycles(RunLen)) u_fault_guard_seq (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .abort       (abort),
    .delayCycles (delayCycles),
    .opEnable    (opEnable),
    .done        (done),
    .alert       (alert),
    .stateCode   (stateCode)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; start = 1'b0; abort = 1'b0;
    @(negedge clk);
    check(stateCode == CodeIdle && !opEnable && !done && !alert, "R1 in reset",
          stateCode, CodeIdle);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(stateCode == CodeIdle && !opEnable && !done && !alert, "R1 after reset",
          stateCode, CodeIdle);
  endtask

  // Full sequence; optionally hold start high while busy (R7).
  task automatic runOp(input int d, input bit holdStart);
    int n;
    int r;
    @(negedge clk);
    delayCycles = 8'(d);
    start = 1'b1;
    @(negedge clk);
    start = holdStart;
    delayCycles = 8'd0;
    check(stateCode == CodeWait, "R2 wait code", stateCode, CodeWait);
    n = 0;
    while (stateCode == CodeWait && n < 1000) begin
      check(!opEnable, "R4 no enable in wait", opEnable, 0);
      n++;
      @(negedge clk);
    end
    check(n == d + 1, holdStart ? "R7 wait length with start held" : "R3 wait length", n, d + 1);
    check(stateCode == CodeRun, "R2 run code", stateCode, CodeRun);
    r = 0;
    while (opEnable && r < 100) begin
      r++;
      if (r == RunLen) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(r == RunLen, "R4 run length", r, RunLen);
    check(done && stateCode == CodeDone, "R5 done pulse", done, 1);
    @(negedge clk);
    check(!done && stateCode == CodeIdle, "R5 back to idle", stateCode, CodeIdle);
  endtask

  task automatic abortInWait();
    @(negedge clk);
    delayCycles = 8'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(stateCode == CodeWait, "R6 still waiting", stateCode, CodeWait);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(stateCode == CodeIdle, "R6 abort in wait", stateCode, CodeIdle);
    for (int i = 0; i < 15; i++) begin
      check(!done && !opEnable, "R6 no done after abort", done, 0);
      @(negedge clk);
    end
  endtask

  task automatic abortInRun();
    @(negedge clk);
    delayCycles = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(opEnable && stateCode == CodeRun, "R6 reached run", stateCode, CodeRun);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(stateCode == CodeIdle && !opEnable, "R6 abort in run", stateCode, CodeIdle);
    for (int i = 0; i < 5; i++) begin
      check(!done, "R6 no done after run abort", done, 0);
      @(negedge clk);
    end
  endtask

  task automatic idleAbort();
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    check(stateCode == CodeIdle, "R7 abort in idle ignored", stateCode, CodeIdle);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    check(stateCode == CodeIdle && !opEnable, "R7 abort blocks start", stateCode, CodeIdle);
  endtask

  task automatic injectFault(input logic [7:0] code, input string what);
    @(negedge clk);
    faultCode = code;
    force u_fault_guard_seq.u_ctrl.stateQ = faultCode;
    #1;
    release u_fault_guard_seq.u_ctrl.stateQ;
    #1;
    check(alert && !opEnable && !done, {"R8 immediate alert ", what}, alert, 1);
    @(negedge clk);
    check(stateCode == CodeError && alert, {"R8 trapped ", what}, stateCode, CodeError);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(stateCode == CodeError && alert && !opEnable && !done, "R9 sticky error",
            stateCode, CodeError);
      @(negedge clk);
    end
    doReset();
    check(stateCode == CodeIdle && !alert, "R9 reset leaves error", stateCode, CodeIdle);
  endtask

  task automatic faultInRun();
    @(negedge clk);
    delayCycles = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(stateCode == CodeRun, "R8 in run before flip", stateCode, CodeRun);
    injectFault(CodeRun ^ 8'h01, "run bit flip");
  endtask

  initial begin
    doReset();
    runOp(0, 1'b0);
    runOp(1, 1'b0);
    runOp(7, 1'b0);
    runOp(255, 1'b0);
    runOp(4, 1'b1);
    abortInWait();
    abortInRun();
    idleAbort();
    runOp(2, 1'b0);
    injectFault(8'h0E, "weight three");
    injectFault(8'hF0, "unlisted weight four");
    faultInRun();
    runOp(3, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule